// File: doc/BRIEF.md
# Cross-Domain Machine Timer

This block keeps a 64-bit machine timer that advances on a reference clock with no fixed phase or frequency relation to the processor clock. A compare register sits on the processor side and raises a timer interrupt once the timer has caught up with it. Software reaches both registers through one small access port in the processor domain. Two synchronised handshakes carry traffic between the domains. A write to the timer is held in a processor-side holding register and is applied in the reference domain through a request/acknowledge pair. A read of the timer is served by a four-phase loop: the reference side latches a snapshot, and only after that does it acknowledge.

The read loop also runs on its own whenever software is not asking for the timer. Each pass refreshes a processor-side shadow copy of the timer, and the interrupt comparator uses that copy. When software asks for the timer, it gets the result of the first full pass that starts after its request was accepted, so the value it sees is never older than the request. With the default 32-bit data path, the timer and the compare register are each reached as separate low and high halves. With a 64-bit data path, each access moves the whole register.

Top module: `xdom_mtimer`

## Requirements
- R1: After reset the timer is zero and then runs, the compare register reads all ones, `timer_irq` is low, `acc_ready` is high and `rd_busy` is low.
- R2: The timer rises by exactly one on every reference-clock edge and nothing can stop it. Two successive timer reads therefore increase, and their difference never exceeds the number of reference edges between the two accesses.
- R3: `acc_sel` value 0 selects the low timer half and value 1 selects the high timer half (bit 0 picks the half; in 64-bit mode bit 0 is ignored). A write replaces only the selected half, and the other half keeps counting.
- R4: Once a timer write is accepted, `acc_ready` stays low and the write data stays frozen until the write handshake has fully returned to idle. Any further access is stalled during that time.
- R5: A timer read raises `rd_busy` from acceptance until the single `rd_valid` pulse. The returned value comes from a snapshot taken after acceptance, and that snapshot is stable while the reference domain acknowledges.
- R6: `acc_sel` values 2 and 3 reach the low and high compare halves. These are written directly in the processor domain. A compare read returns `rd_valid` in the cycle right after acceptance.
- R7: `timer_irq` is high while the processor-side copy of the timer is greater than or equal to the compare value, and low otherwise. It follows a compare write within two processor cycles.
- R8: A carry out of the low timer half advances the high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor clock |
| cpu_rst_n | input | 1 | Processor-domain reset, active low |
| ref_clk | input | 1 | Asynchronous reference clock driving the timer |
| ref_rst_n | input | 1 | Reference-domain reset, active low |
| acc_valid | input | 1 | Access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 2 | 0 timer low, 1 timer high, 2 compare low, 3 compare high |
| acc_wdata | input | DATA_W | Write data |
| acc_ready | output | 1 | Access accepted when high together with acc_valid |
| rd_valid | output | 1 | One-cycle pulse marking rd_data as valid |
| rd_data | output | DATA_W | Read result |
| rd_busy | output | 1 | A timer read is in flight |
| timer_irq | output | 1 | Timer interrupt |

## Verification
If a handshake flag is stuck, a timer read never produces `rd_valid`, or `acc_ready` never returns; either is visible within a few hundred processor cycles. A wrong write mask or a bad snapshot shows up in the very next read of the other half, or as a value outside the window set by the elapsed reference edges. A stale shadow copy makes `timer_irq` late or missing once the timer passes a compare value set just ahead of it.

// File: rtl/xmt_pkg.sv
package xmt_pkg;
    localparam int TIMER_W = 64;
    localparam int HALF_W  = TIMER_W / 2;

    typedef enum logic [1:0] {
        SEL_TIME_LO = 2'd0,
        SEL_TIME_HI = 2'd1,
        SEL_CMP_LO  = 2'd2,
        SEL_CMP_HI  = 2'd3
    } acc_sel_e;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_REQ   = 2'd1,
        HS_DRAIN = 2'd2
    } hs_phase_e;

    typedef struct packed {
        logic [TIMER_W-1:0] count;
        logic [TIMER_W-1:0] snap;
        logic               wr_seen;
        logic               snap_taken;
        logic               rd_ack;
    } ref_state_t;
endpackage

// File: rtl/xmt_sync.sv
module xmt_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/xmt_ref_core.sv
module xmt_ref_core
    import xmt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               ref_clk,
    input  logic               ref_rst_n,
    input  logic               wr_req_a,
    input  logic [TIMER_W-1:0] wr_data,
    input  logic [TIMER_W-1:0] wr_mask,
    input  logic               rd_req_a,
    output logic               wr_ack,
    output logic               rd_ack,
    output logic [TIMER_W-1:0] snap
);
    localparam ref_state_t REF_RESET = '{count: '0, snap: '0, wr_seen: 1'b0,
                                         snap_taken: 1'b0, rd_ack: 1'b0};

    ref_state_t         st_d, st_q;
    logic [1:0]         req_s;
    logic               wr_req_s, rd_req_s;
    logic               apply_w;
    logic [TIMER_W-1:0] count_w;

    xmt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk      (ref_clk),
        .rst_n    (ref_rst_n),
        .async_in ({rd_req_a, wr_req_a}),
        .sync_out (req_s)
    );
    assign wr_req_s = req_s[0];
    assign rd_req_s = req_s[1];

    // a write lands on the first cycle its synchronised request is seen
    assign apply_w = wr_req_s && !st_q.wr_seen;

    always_comb begin
        st_d       = st_q;
        st_d.count = st_q.count + TIMER_W'(1);
        if (apply_w) begin
            st_d.count = (st_q.count & ~wr_mask) | (wr_data & wr_mask);
        end
        st_d.wr_seen = wr_req_s;
        // snapshot first, acknowledge one cycle later
        if (rd_req_s && !st_q.snap_taken) begin
            st_d.snap = st_q.count;
        end
        st_d.snap_taken = rd_req_s;
        st_d.rd_ack     = st_q.snap_taken && rd_req_s;
    end

    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) st_q <= REF_RESET;
        else            st_q <= st_d;
    end

    assign count_w = st_q.count;
    assign wr_ack  = st_q.wr_seen;
    assign rd_ack  = st_q.rd_ack;
    assign snap    = st_q.snap;

    AST_COUNT_STEP: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        !apply_w |=> count_w == $past(count_w) + TIMER_W'(1)); // R2
    AST_SNAP_STABLE: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        rd_ack |-> $stable(snap)); // R5
endmodule

// File: rtl/xmt_cpu_port.sv
module xmt_cpu_port
    import xmt_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               cpu_clk,
    input  logic               cpu_rst_n,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [1:0]         acc_sel,
    input  logic [DATA_W-1:0]  acc_wdata,
    output logic               acc_ready,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_busy,
    output logic               timer_irq,
    output logic               wr_req,
    output logic [TIMER_W-1:0] wr_data,
    output logic [TIMER_W-1:0] wr_mask,
    input  logic               wr_ack_a,
    output logic               rd_req,
    input  logic               rd_ack_a,
    input  logic [TIMER_W-1:0] snap_in
);
    localparam bit HALF_MODE = (DATA_W == HALF_W);
    localparam logic [TIMER_W-1:0] LO_MASK =
        HALF_MODE ? {{HALF_W{1'b0}}, {HALF_W{1'b1}}} : {TIMER_W{1'b1}};
    localparam logic [TIMER_W-1:0] HI_MASK = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};

    typedef struct packed {
        hs_phase_e          wr_phase;
        hs_phase_e          rd_phase;
        logic [TIMER_W-1:0] wr_data;
        logic [TIMER_W-1:0] wr_mask;
        logic [TIMER_W-1:0] shadow;
        logic [TIMER_W-1:0] cmp;
        logic               rd_want;
        logic               rd_armed;
        logic               rd_hi;
        logic               rd_valid;
        logic [DATA_W-1:0]  rd_data;
        logic               irq;
    } cpu_state_t;

    localparam cpu_state_t CPU_RESET = '{wr_phase: HS_IDLE, rd_phase: HS_IDLE,
        wr_data: '0, wr_mask: '0, shadow: '0, cmp: {TIMER_W{1'b1}},
        rd_want: 1'b0, rd_armed: 1'b0, rd_hi: 1'b0, rd_valid: 1'b0,
        rd_data: '0, irq: 1'b0};

    cpu_state_t         st_d, st_q;
    logic [1:0]         ack_s;
    logic               wr_ack_s, rd_ack_s;
    logic               sel_hi;
    logic               accept;
    logic [TIMER_W-1:0] lane_mask, lane_data, wide_data;

    xmt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk      (cpu_clk),
        .rst_n    (cpu_rst_n),
        .async_in ({rd_ack_a, wr_ack_a}),
        .sync_out (ack_s)
    );
    assign wr_ack_s = ack_s[0];
    assign rd_ack_s = ack_s[1];

    generate
        if (HALF_MODE) begin : g_half
            assign sel_hi = acc_sel[0];
        end else begin : g_full
            assign sel_hi = 1'b0;
        end
    endgenerate

    function automatic logic [DATA_W-1:0] pick_lane(input logic [TIMER_W-1:0] v,
                                                   input logic hi);
        logic [TIMER_W-1:0] s;
        s = hi ? (v >> HALF_W) : v;
        return s[DATA_W-1:0];
    endfunction

    always_comb begin
        wide_data             = '0;
        wide_data[DATA_W-1:0] = acc_wdata;
        lane_data             = sel_hi ? (wide_data << HALF_W) : wide_data;
        lane_mask             = sel_hi ? HI_MASK : LO_MASK;
    end

    assign acc_ready = (st_q.wr_phase == HS_IDLE) && !st_q.rd_want && !st_q.rd_armed;
    assign accept    = acc_valid && acc_ready;

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;

        case (st_q.wr_phase)
            HS_REQ:   if (wr_ack_s)  st_d.wr_phase = HS_DRAIN;
            HS_DRAIN: if (!wr_ack_s) st_d.wr_phase = HS_IDLE;
            default:  st_d.wr_phase = HS_IDLE;
        endcase

        // free-running read loop: refreshes the shadow, serves armed reads
        case (st_q.rd_phase)
            HS_IDLE: begin
                st_d.rd_phase = HS_REQ;
                if (st_q.rd_want) begin
                    st_d.rd_want  = 1'b0;
                    st_d.rd_armed = 1'b1;
                end
            end
            HS_REQ: begin
                if (rd_ack_s) begin
                    st_d.shadow   = snap_in;
                    st_d.rd_phase = HS_DRAIN;
                    if (st_q.rd_armed) begin
                        st_d.rd_armed = 1'b0;
                        st_d.rd_valid = 1'b1;
                        st_d.rd_data  = pick_lane(snap_in, st_q.rd_hi);
                    end
                end
            end
            HS_DRAIN: if (!rd_ack_s) st_d.rd_phase = HS_IDLE;
            default:  st_d.rd_phase = HS_IDLE;
        endcase

        if (accept) begin
            if (acc_sel[1]) begin
                if (acc_write) begin
                    st_d.cmp = (st_q.cmp & ~lane_mask) | (lane_data & lane_mask);
                end else begin
                    st_d.rd_valid = 1'b1;
                    st_d.rd_data  = pick_lane(st_q.cmp, sel_hi);
                end
            end else if (acc_write) begin
                st_d.wr_phase = HS_REQ;
                st_d.wr_data  = lane_data;
                st_d.wr_mask  = lane_mask;
            end else begin
                st_d.rd_want = 1'b1;
                st_d.rd_hi   = sel_hi;
            end
        end

        st_d.irq = (st_q.shadow >= st_q.cmp);
    end

    always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
        if (!cpu_rst_n) st_q <= CPU_RESET;
        else            st_q <= st_d;
    end

    assign wr_req    = (st_q.wr_phase == HS_REQ);
    assign wr_data   = st_q.wr_data;
    assign wr_mask   = st_q.wr_mask;
    assign rd_req    = (st_q.rd_phase == HS_REQ);
    assign rd_valid  = st_q.rd_valid;
    assign rd_data   = st_q.rd_data;
    assign rd_busy   = st_q.rd_want || st_q.rd_armed;
    assign timer_irq = st_q.irq;

    AST_WRITE_STALL: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        wr_req |-> !acc_ready); // R4
    AST_HOLD_STABLE: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        (wr_req && $past(wr_req)) |-> ($stable(wr_data) && $stable(wr_mask))); // R4
    AST_REQ_DROP_AFTER_ACK: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        $fell(rd_req) |-> $past(rd_ack_s)); // R5
    AST_VALID_ENDS_BUSY: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        rd_valid |-> !rd_busy); // R5
endmodule

// File: rtl/xdom_mtimer.sv
module xdom_mtimer
    import xmt_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              cpu_clk,
    input  logic              cpu_rst_n,
    input  logic              ref_clk,
    input  logic              ref_rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_sel,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              acc_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_busy,
    output logic              timer_irq
);
    logic               wr_req, wr_ack, rd_req, rd_ack;
    logic [TIMER_W-1:0] wr_data, wr_mask, snap;

    xmt_cpu_port #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_cpu_port (
        .cpu_clk   (cpu_clk),
        .cpu_rst_n (cpu_rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_sel   (acc_sel),
        .acc_wdata (acc_wdata),
        .acc_ready (acc_ready),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_busy   (rd_busy),
        .timer_irq (timer_irq),
        .wr_req    (wr_req),
        .wr_data   (wr_data),
        .wr_mask   (wr_mask),
        .wr_ack_a  (wr_ack),
        .rd_req    (rd_req),
        .rd_ack_a  (rd_ack),
        .snap_in   (snap)
    );

    xmt_ref_core #(.SYNC_STAGES(SYNC_STAGES)) u_ref_core (
        .ref_clk   (ref_clk),
        .ref_rst_n (ref_rst_n),
        .wr_req_a  (wr_req),
        .wr_data   (wr_data),
        .wr_mask   (wr_mask),
        .rd_req_a  (rd_req),
        .wr_ack    (wr_ack),
        .rd_ack    (rd_ack),
        .snap      (snap)
    );
endmodule

// File: tb/xdom_mtimer_bench.sv
module xdom_mtimer_bench;
    localparam int CPU_PERIOD = 10;
    localparam int REF_PERIOD = 14;
    localparam int DW         = 32;

    logic          cpu_clk = 1'b0, ref_clk = 1'b0;
    logic          cpu_rst_n = 1'b0, ref_rst_n = 1'b0;
    logic          acc_valid = 1'b0, acc_write = 1'b0;
    logic [1:0]    acc_sel = 2'd0;
    logic [DW-1:0] acc_wdata = '0;
    logic          acc_ready, rd_valid, rd_busy, timer_irq;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int fails  = 0;
    longint unsigned ref_edges = 0;

    always #(CPU_PERIOD/2) cpu_clk = ~cpu_clk;
    always #(REF_PERIOD/2) ref_clk = ~ref_clk;
    always @(posedge ref_clk) ref_edges <= ref_edges + 1;

    xdom_mtimer #(.DATA_W(DW)) u_xdom_mtimer (
        .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_sel(acc_sel), .acc_wdata(acc_wdata),
        .acc_ready(acc_ready), .rd_valid(rd_valid), .rd_data(rd_data), .rd_busy(rd_busy),
        .timer_irq(timer_irq)
    );

    function automatic bit in_window(input longint unsigned v, input longint unsigned base,
                                     input longint unsigned span);
        return (v >= base) && (v - base <= span);
    endfunction

    function automatic logic [31:0] carried_hi(input logic [31:0] h);
        return h + 32'd1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [1:0] sel, input logic [DW-1:0] data,
                          output longint unsigned at_edge);
        @(negedge cpu_clk);
        while (!acc_ready) @(negedge cpu_clk);
        acc_valid = 1'b1; acc_write = wr; acc_sel = sel; acc_wdata = data;
        @(posedge cpu_clk);
        at_edge = ref_edges;
        @(negedge cpu_clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic do_write(input logic [1:0] sel, input logic [DW-1:0] data,
                            output longint unsigned at_edge);
        access(1'b1, sel, data, at_edge);
    endtask

    task automatic do_read(input logic [1:0] sel, output logic [DW-1:0] v,
                           output longint unsigned at_acc, output longint unsigned at_done,
                           output int lat, output bit busy_seen);
        bit got;
        access(1'b0, sel, '0, at_acc);
        busy_seen = rd_busy;
        got = 1'b0; lat = -1; v = '0; at_done = 0;
        for (int i = 0; i < 300; i++) begin
            if (rd_valid) begin
                v = rd_data; lat = i; at_done = ref_edges; got = 1'b1;
                break;
            end
            @(negedge cpu_clk);
        end
        check(got, "R5", "rd_valid arrival", longint'(got), 1);
    endtask

    task automatic wait_ref(input longint unsigned until_edge);
        while (ref_edges < until_edge) @(posedge ref_clk);
        @(negedge cpu_clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge cpu_clk);
        checks++; fails++;
        $display("FAIL R5 watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [DW-1:0] v, v2, h, c;
        longint unsigned a0, a1, d0, d1, wl, rel;
        int lat;
        bit busy;
        void'($urandom(32'h5EED_0042));

        repeat (5) @(negedge cpu_clk);
        cpu_rst_n = 1'b1;
        @(negedge ref_clk); ref_rst_n = 1'b1;
        rel = ref_edges;
        repeat (3) @(negedge cpu_clk);

        // R1 reset state
        check(acc_ready == 1'b1, "R1", "acc_ready after reset", acc_ready, 1);
        check(rd_busy == 1'b0, "R1", "rd_busy after reset", rd_busy, 0);
        check(timer_irq == 1'b0, "R1", "irq after reset", timer_irq, 0);
        do_read(2'd2, v, a0, d0, lat, busy);
        check(v == 32'hFFFF_FFFF, "R1", "compare low reset", v, 32'hFFFF_FFFF);
        do_read(2'd3, v, a0, d0, lat, busy);
        check(v == 32'hFFFF_FFFF, "R1", "compare high reset", v, 32'hFFFF_FFFF);
        do_read(2'd1, v, a0, d0, lat, busy);
        check(v == 32'd0, "R1", "timer high reset", v, 0);
        do_read(2'd0, v, a0, d0, lat, busy);
        check(in_window(v, 0, d0 - rel + 1), "R1", "timer low counts from zero", v, d0 - rel);
        check(timer_irq == 1'b0, "R1", "no spurious irq", timer_irq, 0);

        // R4 stall after timer write
        do_write(2'd0, 32'd0, wl);
        check(acc_ready == 1'b0, "R4", "ready low while write pending", acc_ready, 0);

        // R3 half write
        h = 32'hA5A5_0001;
        do_write(2'd1, h, a0);
        check(acc_ready == 1'b0, "R4", "ready low after high write", acc_ready, 0);
        do_read(2'd1, v, a0, d0, lat, busy);
        check(v == h, "R3", "high half after write", v, h);
        do_read(2'd0, v, a0, d0, lat, busy);
        check(in_window(v, 0, d0 - wl + 1), "R3", "low half kept counting", v, d0 - wl);

        // R2 monotonic, bounded by reference edges
        do_read(2'd0, v, a0, d0, lat, busy);
        do_read(2'd0, v2, a1, d1, lat, busy);
        check(v2 > v, "R2", "second read larger", v2, v + 1);
        check(longint'(v2 - v) <= longint'(d1 - a0 + 1), "R2", "step within edges",
              v2 - v, d1 - a0);

        // R5 fresh value after a write, busy flag
        c = 32'h1000_0000 | ($urandom & 32'h000F_FFFF);
        do_write(2'd0, c, wl);
        do_read(2'd0, v, a0, d0, lat, busy);
        check(busy == 1'b1, "R5", "rd_busy after accept", busy, 1);
        check(rd_busy == 1'b0, "R5", "rd_busy clear with rd_valid", rd_busy, 0);
        check(in_window(v, c, d0 - wl + 1), "R5", "read not older than write", v, c);

        // R6 compare halves
        c = $urandom;
        do_write(2'd2, c, a0);
        do_read(2'd2, v, a0, d0, lat, busy);
        check(v == c, "R6", "compare low readback", v, c);
        check(lat == 0, "R6", "compare read latency", lat, 0);
        h = $urandom;
        do_write(2'd3, h, a0);
        do_read(2'd3, v, a0, d0, lat, busy);
        check(v == h, "R6", "compare high readback", v, h);
        do_read(2'd2, v, a0, d0, lat, busy);
        check(v == c, "R6", "compare low untouched by high write", v, c);

        // R8 carry from low into high
        do_write(2'd1, 32'd5, a0);
        do_write(2'd0, 32'hFFFF_FF00, wl);
        do_read(2'd1, v, a0, d0, lat, busy);
        check(v == 32'd5, "R8", "high before carry", v, 5);
        wait_ref(wl + 400);
        do_read(2'd1, v, a0, d0, lat, busy);
        check(v == carried_hi(32'd5), "R8", "high after carry", v, carried_hi(32'd5));

        // R7 interrupt against compare
        do_write(2'd0, 32'd0, wl);
        do_write(2'd1, 32'd0, a0);
        do_write(2'd2, 32'd3000, a0);
        do_write(2'd3, 32'd0, a0);
        repeat (10) @(negedge cpu_clk);
        check(timer_irq == 1'b0, "R7", "irq low below compare", timer_irq, 0);
        wait_ref(wl + 3100);
        repeat (60) @(negedge cpu_clk);
        check(timer_irq == 1'b1, "R7", "irq high past compare", timer_irq, 1);
        do_write(2'd3, 32'hFFFF_FFFF, a0);
        @(negedge cpu_clk);
        check(timer_irq == 1'b0, "R7", "irq drops after compare raise", timer_irq, 0);
        do_write(2'd2, 32'd0, a0);
        do_write(2'd3, 32'd0, a0);
        repeat (2) @(negedge cpu_clk);
        check(timer_irq == 1'b1, "R7", "irq with zero compare", timer_irq, 1);

        // random half writes and readbacks
        for (int k = 0; k < 16; k++) begin
            h = $urandom & 32'hFFFF_FFFE;
            do_write(2'd0, 32'd0, a0);
            do_write(2'd1, h, a0);
            do_read(2'd1, v, a0, d0, lat, busy);
            check(v == h, "R3", "random high write", v, h);
            c = $urandom;
            do_write({1'b1, c[0]}, c, a0);
            do_read({1'b1, c[0]}, v, a0, d0, lat, busy);
            check(v == c, "R6", "random compare half", v, c);
        end

        finish_run();
    end
endmodule